// File: doc/BRIEF.md
# Playback Mute and Headphone Router

This block sits between the playback sample stream and the eight line-output converters plus the headphone converter pair. Each sample period a strobe presents eight signed 16-bit channel samples. The block decides per channel whether the channel is silenced, picks which speaker pair feeds the headphone outputs, and re-codes every sample into the 17-bit unsigned code that the converters expect. That code is offset-binary with a fixed lift of 64.

A single 16-bit control word carries three things: a driver-present flag, a two-bit headphone source field and a ten-bit silence mask. A jack-sense input reports a plugged headphone. When a headphone is plugged and no driver has claimed the device, a fallback applies. All speaker channels go quiet and the headphones hear the front pair, whatever the mask and source field say. All ten output codes are registered and change only on a strobe.

Top module: `pb_route_top`

## Requirements
- R1: While `rst` is high at a clock edge, all ten output codes become the mid-scale code 32832 at that edge.
- R2: When a strobe is captured with `jack_sense`=1 and control bit 15 = 0, the eight speaker codes (lanes 0..7) are all 32832 after that edge, regardless of the mask.
- R3: In the fallback of R2, headphone lanes 8 and 9 carry lanes 0 and 1 (front left, front right), regardless of control bits 14..13.
- R4: Outside the fallback, control bit 3+i silences lane i for i in 0..9. Lanes 0..7 are front L, front R, center, subwoofer, surround L, surround R, side L, side R. Lane 8 is headphone L and lane 9 is headphone R. A silenced lane outputs 32832.
- R5: Outside the fallback, control bits 14..13 select the headphone source pair: 00 lanes 0/1, 01 lanes 2/3, 10 lanes 4/5, 11 lanes 6/7. Lane 8 takes the even lane and lane 9 takes the odd lane.
- R6: An unsilenced lane outputs (sample + 32768) + 64 as 17-bit unsigned: -32768 gives 64, 0 gives 32832, 32767 gives 65599.
- R7: Output codes change only at a clock edge where `smp_stb` is 1. They hold while the strobe is low, whatever the other inputs do.
- R8: With control bit 15 = 1, `jack_sense` has no effect: mask and source field rule as in R4 and R5.
- R9: In the fallback, the headphone lanes are still silenced by control bits 11 (lane 8) and 12 (lane 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; captures the inputs at this edge |
| smp_in | input | 128 | Eight signed samples; lane i at bits [16*i+15:16*i] |
| ctrl_word | input | 16 | Bit 15 driver present, 14..13 headphone source, 12..3 silence mask |
| jack_sense | input | 1 | Headphone plugged when 1 |
| code_out | output | 170 | Ten unsigned codes; lane i at bits [17*i+16:17*i], lanes 8/9 headphone |

## Verification
A wrong fallback decode shows as a speaker lane carrying sample data, or as headphones fed from the wrong pair. It appears on the first strobe after the jack and driver condition is set. A wrong lane index in the mask or the pair select shows at once as a neighbouring lane silenced or routed. Conversion faults show as codes off by the sign weight or the lift at the extreme and zero samples. A missing strobe gate shows as codes that drift while the strobe is low.

// File: rtl/pb_route_pkg.sv
package pb_route_pkg;

    localparam int SPK_CH   = 8;
    localparam int HP_CH    = 2;
    localparam int OUT_CH   = SPK_CH + HP_CH;
    localparam int SMP_W    = 16;
    localparam int CODE_W   = SMP_W + 1;
    localparam int CODE_OFS = 64;
    localparam int CTRL_W   = 16;
    localparam int MASK_LSB = 3;
    localparam int SEL_LSB  = 13;
    localparam int DRV_BIT  = 15;
    localparam int PAIRS    = SPK_CH / 2;
    localparam int SEL_W    = $clog2(PAIRS);

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'((1 << (SMP_W - 1)) + CODE_OFS);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'((1 << SMP_W) - 1 + CODE_OFS);

    typedef enum logic [SEL_W-1:0] {
        SRC_FRONT  = 2'b00,
        SRC_CTRLFE = 2'b01,
        SRC_SURR   = 2'b10,
        SRC_SIDE   = 2'b11
    } hp_src_e;

    typedef struct packed {
        logic              drv_on;
        hp_src_e           hp_src;
        logic [OUT_CH-1:0] mute;
    } ctrl_t;

    typedef logic [SPK_CH-1:0][SMP_W-1:0] spk_bus_t;
    typedef logic [HP_CH-1:0][SMP_W-1:0]  hp_bus_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.drv_on = w[DRV_BIT];
        c.hp_src = hp_src_e'(w[SEL_LSB +: SEL_W]);
        c.mute   = w[MASK_LSB +: OUT_CH];
        return c;
    endfunction

    // Flip the sign bit, zero-extend, add the fixed lift.
    function automatic logic [CODE_W-1:0] to_code(input logic [SMP_W-1:0] s);
        logic [CODE_W-1:0] ob;
        ob = {1'b0, ~s[SMP_W-1], s[SMP_W-2:0]};
        return ob + CODE_W'(CODE_OFS);
    endfunction

endpackage

// File: rtl/pb_ctrl_decode.sv
module pb_ctrl_decode
    import pb_route_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              jack_sense,
    output logic [OUT_CH-1:0] eff_mute,
    output hp_src_e           eff_src,
    output logic              fallback
);
    ctrl_t c;

    always_comb begin
        c        = unpack_ctrl(ctrl_word);
        fallback = jack_sense && !c.drv_on;
        eff_mute = c.mute;
        eff_src  = c.hp_src;
        if (fallback) begin
            eff_mute[SPK_CH-1:0] = '1;
            eff_src              = SRC_FRONT;
        end
    end
endmodule

// File: rtl/pb_hp_select.sv
module pb_hp_select
    import pb_route_pkg::*;
(
    input  spk_bus_t spk_i,
    input  hp_src_e  src_i,
    output hp_bus_t  hp_o
);
    logic [SEL_W:0] base;

    always_comb begin
        base = {src_i, 1'b0};
    end

    for (genvar k = 0; k < HP_CH; k++) begin : g_hp
        always_comb begin
            hp_o[k] = spk_i[int'(base) + k];
        end
    end
endmodule

// File: rtl/pb_code_lane.sv
module pb_code_lane
    import pb_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic              mute_i,
    input  logic [SMP_W-1:0]  smp_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = mute_i ? MID_CODE : to_code(smp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= MID_CODE;
        end else if (stb_i) begin
            code_o <= code_d;
        end
    end

    AST_MUTE_MID: assert property (@(posedge clk) disable iff (rst)
        (stb_i && mute_i) |=> (code_o == MID_CODE)); // R4

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(code_o)); // R7

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (code_o >= CODE_W'(CODE_OFS)) && (code_o <= MAX_CODE)); // R6
endmodule

// File: rtl/pb_route_top.sv
module pb_route_top
    import pb_route_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_stb,
    input  logic [SPK_CH*SMP_W-1:0]   smp_in,
    input  logic [CTRL_W-1:0]         ctrl_word,
    input  logic                      jack_sense,
    output logic [OUT_CH*CODE_W-1:0]  code_out
);
    logic [OUT_CH-1:0] eff_mute;
    hp_src_e           eff_src;
    logic              fallback;
    spk_bus_t          spk_bus;
    hp_bus_t           hp_bus;
    logic [OUT_CH-1:0][SMP_W-1:0] lane_smp;

    always_comb begin
        spk_bus = spk_bus_t'(smp_in);
    end

    pb_ctrl_decode u_dec (
        .ctrl_word  (ctrl_word),
        .jack_sense (jack_sense),
        .eff_mute   (eff_mute),
        .eff_src    (eff_src),
        .fallback   (fallback)
    );

    pb_hp_select u_sel (
        .spk_i (spk_bus),
        .src_i (eff_src),
        .hp_o  (hp_bus)
    );

    for (genvar i = 0; i < OUT_CH; i++) begin : g_lane
        if (i < SPK_CH) begin : g_spk
            always_comb lane_smp[i] = spk_bus[i];
        end else begin : g_hp
            always_comb lane_smp[i] = hp_bus[i-SPK_CH];
        end

        pb_code_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .stb_i  (smp_stb),
            .mute_i (eff_mute[i]),
            .smp_i  (lane_smp[i]),
            .code_o (code_out[i*CODE_W +: CODE_W])
        );
    end

    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> (code_out == {OUT_CH{MID_CODE}})); // R1

    AST_FALLBACK_SPK: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && jack_sense && !ctrl_word[DRV_BIT])
        |=> (code_out[SPK_CH*CODE_W-1:0] == {SPK_CH{MID_CODE}})); // R2

    AST_FALLBACK_HP_FRONT: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && jack_sense && !ctrl_word[DRV_BIT] && !ctrl_word[MASK_LSB+SPK_CH])
        |=> (code_out[SPK_CH*CODE_W +: CODE_W] == to_code($past(smp_in[SMP_W-1:0])))); // R3

    AST_FALLBACK_FLAG: assert property (@(posedge clk) disable iff (rst)
        fallback |-> (jack_sense && eff_src == SRC_FRONT)); // R3
endmodule

// File: tb/pb_route_top_test.sv
`timescale 1ns/1ps
module pb_route_top_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         smp_stb;
    logic [127:0] smp_in;
    logic [15:0]  ctrl_word;
    logic         jack_sense;
    logic [169:0] code_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] cur_s [8];

    always #2.5 clk = ~clk;

    pb_route_top uut (
        .clk        (clk),
        .rst        (rst),
        .smp_stb    (smp_stb),
        .smp_in     (smp_in),
        .ctrl_word  (ctrl_word),
        .jack_sense (jack_sense),
        .code_out   (code_out)
    );

    function automatic logic [16:0] conv(input logic [15:0] s);
        int v;
        v = int'($signed(s)) + 32768 + 64;
        return 17'(v);
    endfunction

    function automatic logic [16:0] model(input int ch, input logic [15:0] cw, input logic js);
        bit ovr, muted;
        int src;
        ovr = js && !cw[15];
        if (ch < 8) begin
            muted = ovr ? 1'b1 : cw[3+ch];
            src   = ch;
        end else begin
            muted = cw[3+ch];
            src   = (ovr ? 0 : int'(cw[14:13])) * 2 + (ch - 8);
        end
        return muted ? 17'd32832 : conv(cur_s[src]);
    endfunction

    task automatic chk(input string tag, input int ch, input logic [16:0] exp);
        logic [16:0] act;
        act = code_out[ch*17 +: 17];
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual %0d expected %0d", tag, ch, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] s0, s1, s2, s3, s4, s5, s6, s7);
        cur_s = '{s0, s1, s2, s3, s4, s5, s6, s7};
        for (int i = 0; i < 8; i++) smp_in[i*16 +: 16] = cur_s[i];
    endtask

    task automatic strobe(input logic [15:0] cw, input logic js);
        @(negedge clk);
        ctrl_word  = cw;
        jack_sense = js;
        smp_stb    = 1'b1;
        @(negedge clk);
        smp_stb    = 1'b0;
    endtask

    task automatic check_all(input string tag, input logic [15:0] cw, input logic js);
        for (int i = 0; i < 10; i++) chk(tag, i, model(i, cw, js));
    endtask

    task automatic t_reset;
        load(16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h0123);
        strobe(16'h0000, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 10; i++) chk("R1 reset", i, 17'd32832);
    endtask

    task automatic t_convert;
        load(16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001, 16'hC000, 16'h4000, 16'h8001);
        strobe(16'h0000, 1'b0);
        chk("R6 min", 0, 17'd64);
        chk("R6 max", 1, 17'd65599);
        chk("R6 zero", 2, 17'd32832);
        chk("R6 minus one", 3, 17'd32831);
        check_all("R6", 16'h0000, 1'b0);
    endtask

    task automatic t_mask;
        load(16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'h5000, 16'h6000, 16'h7000, 16'hF000);
        strobe(16'b0_00_1010101010_000, 1'b0);
        check_all("R4 alt mask", 16'b0_00_1010101010_000, 1'b0);
        strobe(16'b0_00_0101010101_000, 1'b0);
        check_all("R4 inv mask", 16'b0_00_0101010101_000, 1'b0);
        strobe(16'b0_00_1111111111_000, 1'b0);
        for (int i = 0; i < 10; i++) chk("R4 all muted", i, 17'd32832);
    endtask

    task automatic t_hpsel;
        load(16'h0101, 16'h0202, 16'h0303, 16'h0404, 16'h0505, 16'h0606, 16'h0707, 16'h0808);
        for (int s = 0; s < 4; s++) begin
            logic [15:0] cw;
            cw = {1'b0, 2'(s), 13'h0};
            strobe(cw, 1'b0);
            chk("R5 hp left", 8, conv(cur_s[2*s]));
            chk("R5 hp right", 9, conv(cur_s[2*s+1]));
        end
    endtask

    task automatic t_fallback;
        logic [15:0] cw;
        load(16'h8000, 16'h7FFF, 16'h1234, 16'h2345, 16'h3456, 16'h4567, 16'h5678, 16'h6789);
        cw = {1'b0, 2'b11, 10'b0000000000, 3'b000};
        strobe(cw, 1'b1);
        for (int i = 0; i < 8; i++) chk("R2 speakers quiet", i, 17'd32832);
        chk("R3 hp front L", 8, 17'd64);
        chk("R3 hp front R", 9, 17'd65599);
        cw = {1'b0, 2'b10, 10'b1000000000, 3'b000};
        strobe(cw, 1'b1);
        chk("R9 hp L live", 8, 17'd64);
        chk("R9 hp R muted", 9, 17'd32832);
        cw = {1'b0, 2'b01, 10'b0100000000, 3'b000};
        strobe(cw, 1'b1);
        chk("R9 hp L muted", 8, 17'd32832);
        chk("R9 hp R live", 9, 17'd65599);
    endtask

    task automatic t_driver;
        logic [15:0] cw;
        load(16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055, 16'h0066, 16'h0077, 16'h0088);
        cw = {1'b1, 2'b10, 10'b0000000101, 3'b000};
        strobe(cw, 1'b1);
        check_all("R8 driver present", cw, 1'b1);
        chk("R8 speaker live", 1, conv(16'h0022));
        chk("R8 hp from surround", 8, conv(16'h0055));
    endtask

    task automatic t_hold;
        logic [16:0] snap [10];
        load(16'h0AAA, 16'h0BBB, 16'h0CCC, 16'h0DDD, 16'h0EEE, 16'h0FFF, 16'h1AAA, 16'h1BBB);
        strobe(16'h0000, 1'b0);
        for (int i = 0; i < 10; i++) snap[i] = code_out[i*17 +: 17];
        load(16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        ctrl_word  = 16'b0_11_1111111111_000;
        jack_sense = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 10; i++) chk("R7 hold without strobe", i, snap[i]);
    endtask

    initial begin
        rst = 1'b1; smp_stb = 1'b0; smp_in = '0; ctrl_word = '0; jack_sense = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 10; i++) chk("R1 initial", i, 17'd32832);
        rst = 1'b0;
        t_convert();
        t_mask();
        t_hpsel();
        t_fallback();
        t_driver();
        t_hold();
        t_reset();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule